// File: doc/BRIEF.md
# Sub-word Register Access Adapter

This block sits between a host that issues byte, halfword, three-byte or word accesses into a 128-byte I/O window and a set of register files that only understand whole aligned 32-bit words. It sorts each host address into one of three regions: a core register file in the low 64 bytes, a DMA register file in the next 32 bytes, and a single control word. Each region has its own word-wide register port. Everything else in the window is empty.

A narrow or unaligned write becomes a read-modify-write. The adapter first fetches the current word from the target register. It then writes that word back with only the addressed byte lanes replaced. A read makes one whole-word fetch, and the adapter shifts and masks the result down to the requested width. The window is little-endian. Register reads may have side effects, so the adapter never makes more than one internal read for a host access. The host holds `host_req` until it sees the single-cycle `host_ready` pulse, then drops it.

Top module: `subword_adapter`

## Requirements
- R1: While and directly after reset, `host_ready`, `host_rdata` and all region enables are 0.
- R2: Byte addresses below 0x40 select the core port with index addr>>2.
- R3: Byte addresses 0x40 to 0x5F select the DMA port with index (addr-0x40)>>2.
- R4: Byte addresses 0x70 to 0x73 select the control port. At most one region enable is high in any cycle.
- R5: An access to any other address asserts no region enable. It completes with `host_ready` one clock edge after acceptance. A read of such an address returns 0, and a write to it changes no register.
- R6: A 4-byte write at an address whose low two bits are 0 makes exactly one internal write with the host data and no internal read. `host_ready` is seen two edges after acceptance.
- R7: Any other write first reads the target word, then writes it back with bytes outside the addressed lanes unchanged. `host_ready` is seen three edges after acceptance.
- R8: Write byte k of `host_wdata` lands in lane (addr&3)+k for k below the access size. Lanes that would lie beyond bit 31 are discarded.
- R9: `host_size` encodes bytes-1 (0 gives 1 byte, 3 gives 4 bytes). A read returns the word shifted right by 8×(addr&3) and masked to 8×bytes bits, two edges after acceptance.
- R10: Each host read makes exactly one internal read, and a write makes at most one.
- R11: `host_ready` is high for exactly one cycle per access, and `host_rdata` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, held until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address in the window |
| host_size | input | 2 | Access size in bytes minus one |
| host_wdata | input | 32 | Write data, right-aligned |
| host_ready | output | 1 | Completion pulse |
| host_rdata | output | 32 | Read data, right-aligned |
| core_en | output | 1 | Core register port strobe |
| core_we | output | 1 | Core port write enable |
| core_idx | output | CORE_IDX_W | Core register index |
| core_wdata | output | 32 | Core write word |
| core_rdata | input | 32 | Core read word (same cycle) |
| dma_en | output | 1 | DMA register port strobe |
| dma_we | output | 1 | DMA port write enable |
| dma_idx | output | DMA_IDX_W | DMA register index |
| dma_wdata | output | 32 | DMA write word |
| dma_rdata | input | 32 | DMA read word (same cycle) |
| ctl_en | output | 1 | Control register strobe |
| ctl_we | output | 1 | Control write enable |
| ctl_wdata | output | 32 | Control write word |
| ctl_rdata | input | 32 | Control read word (same cycle) |

## Verification
The bench builds the adapter with its default parameters: a 7-bit address, the core region ending at 0x40, the DMA region ending at 0x60 and the control word at 0x70. With these values, every size and byte-offset pair can be reached on a real register. So can the edges 0x3F/0x40 and 0x5F/0x60, and the empty holes at 0x60 to 0x6F and 0x74 to 0x7F. The register files are modelled behind the three ports with known contents. This lets the bench compare each merged word and each extracted lane against values it computes itself. It also counts the internal reads and writes per access.

// File: rtl/subword_pkg.sv
package subword_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_CORE,
        RG_DMA,
        RG_CTL
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRITE,
        ST_READ,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic    we;
        region_e region;
        logic    widen;
        logic [1:0] off;
        logic [1:0] size;
        word_t   wdata;
    } xfer_t;

    // Lanes touched by an access of (size+1) bytes starting at lane off.
    function automatic logic [WORD_BYTES-1:0] lane_enables(input logic [1:0] off,
                                                            input logic [1:0] size);
        logic [WORD_BYTES-1:0] m;
        logic [2:0] lo;
        logic [2:0] hi;
        lo = {1'b0, off};
        hi = {1'b0, off} + {1'b0, size};
        for (int i = 0; i < WORD_BYTES; i++) begin
            m[i] = (3'(i) >= lo) && (3'(i) <= hi);
        end
        return m;
    endfunction

    function automatic word_t bytes_to_bits(input logic [WORD_BYTES-1:0] m);
        word_t b;
        for (int i = 0; i < WORD_BYTES; i++) begin
            b[8*i +: 8] = {8{m[i]}};
        end
        return b;
    endfunction

    function automatic word_t extract_lanes(input word_t w, input logic [1:0] off,
                                            input logic [1:0] size);
        word_t s;
        s = w >> {off, 3'b000};
        case (size)
            2'd0:    return {24'd0, s[7:0]};
            2'd1:    return {16'd0, s[15:0]};
            2'd2:    return {8'd0, s[23:0]};
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/subword_decode.sv
module subword_decode
    import subword_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int CORE_END = 64,
    parameter int DMA_END  = 96,
    parameter int CTL_ADDR = 112,
    parameter int IDX_W    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] rel;

    always_comb begin
        region = RG_NONE;
        idx    = '0;
        rel    = '0;
        if (addr < ADDR_W'(CORE_END)) begin
            region = RG_CORE;
            idx    = IDX_W'(addr >> 2);
        end else if (addr < ADDR_W'(DMA_END)) begin
            region = RG_DMA;
            rel    = addr - ADDR_W'(CORE_END);
            idx    = IDX_W'(rel >> 2);
        end else if ((addr >> 2) == (ADDR_W'(CTL_ADDR) >> 2)) begin
            region = RG_CTL;
        end
    end
endmodule

// File: rtl/subword_lanes.sv
module subword_lanes
    import subword_pkg::*;
(
    input  word_t      cur_word,
    input  word_t      new_data,
    input  word_t      fetched,
    input  logic [1:0] off,
    input  logic [1:0] size,
    output word_t      merged,
    output word_t      rd_lanes
);
    word_t keep_mask;
    word_t placed;

    always_comb begin
        keep_mask = bytes_to_bits(lane_enables(off, size));
        placed    = new_data << {off, 3'b000};
        merged    = (cur_word & ~keep_mask) | (placed & keep_mask);
        rd_lanes  = extract_lanes(fetched, off, size);
    end
endmodule

// File: rtl/subword_adapter.sv
module subword_adapter
    import subword_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int CORE_END = 64,
    parameter int DMA_END  = 96,
    parameter int CTL_ADDR = 112,
    localparam int CORE_IDX_W = $clog2(CORE_END / 4),
    localparam int DMA_IDX_W  = $clog2((DMA_END - CORE_END) / 4)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [1:0]            host_size,
    input  logic [31:0]           host_wdata,
    output logic                  host_ready,
    output logic [31:0]           host_rdata,
    output logic                  core_en,
    output logic                  core_we,
    output logic [CORE_IDX_W-1:0] core_idx,
    output logic [31:0]           core_wdata,
    input  logic [31:0]           core_rdata,
    output logic                  dma_en,
    output logic                  dma_we,
    output logic [DMA_IDX_W-1:0]  dma_idx,
    output logic [31:0]           dma_wdata,
    input  logic [31:0]           dma_rdata,
    output logic                  ctl_en,
    output logic                  ctl_we,
    output logic [31:0]           ctl_wdata,
    input  logic [31:0]           ctl_rdata
);
    state_e                state_q;
    xfer_t                 xfer_q;
    logic [CORE_IDX_W-1:0] idx_q;
    word_t                 cur_q;
    word_t                 rdata_q;

    region_e               dec_region;
    logic [CORE_IDX_W-1:0] dec_idx;
    word_t                 sel_rdata;
    word_t                 merged;
    word_t                 rd_lanes;
    word_t                 wr_word;
    logic                  port_active;
    logic                  port_we;
    logic                  rd_any;
    logic                  wr_any;

    subword_decode #(
        .ADDR_W  (ADDR_W),
        .CORE_END(CORE_END),
        .DMA_END (DMA_END),
        .CTL_ADDR(CTL_ADDR),
        .IDX_W   (CORE_IDX_W)
    ) u_decode (
        .addr  (host_addr),
        .region(dec_region),
        .idx   (dec_idx)
    );

    subword_lanes u_lanes (
        .cur_word(cur_q),
        .new_data(xfer_q.wdata),
        .fetched (sel_rdata),
        .off     (xfer_q.off),
        .size    (xfer_q.size),
        .merged  (merged),
        .rd_lanes(rd_lanes)
    );

    always_comb begin
        case (xfer_q.region)
            RG_CORE: sel_rdata = core_rdata;
            RG_DMA:  sel_rdata = dma_rdata;
            RG_CTL:  sel_rdata = ctl_rdata;
            default: sel_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            xfer_q  <= '0;
            idx_q   <= '0;
            cur_q   <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (host_req) begin
                        xfer_q.we     <= host_we;
                        xfer_q.region <= dec_region;
                        xfer_q.widen  <= (host_size != 2'd3) || (host_addr[1:0] != 2'd0);
                        xfer_q.off    <= host_addr[1:0];
                        xfer_q.size   <= host_size;
                        xfer_q.wdata  <= host_wdata;
                        idx_q         <= dec_idx;
                        rdata_q       <= '0;
                        if (dec_region == RG_NONE)
                            state_q <= ST_DONE;
                        else if (!host_we)
                            state_q <= ST_READ;
                        else if ((host_size != 2'd3) || (host_addr[1:0] != 2'd0))
                            state_q <= ST_FETCH;
                        else
                            state_q <= ST_WRITE;
                    end
                end
                ST_FETCH: begin
                    cur_q   <= sel_rdata;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: state_q <= ST_DONE;
                ST_READ: begin
                    rdata_q <= rd_lanes;
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        port_active = (state_q == ST_FETCH) || (state_q == ST_WRITE) || (state_q == ST_READ);
        port_we     = (state_q == ST_WRITE);
        wr_word     = xfer_q.widen ? merged : xfer_q.wdata;

        core_en    = port_active && (xfer_q.region == RG_CORE);
        dma_en     = port_active && (xfer_q.region == RG_DMA);
        ctl_en     = port_active && (xfer_q.region == RG_CTL);
        core_we    = core_en && port_we;
        dma_we     = dma_en && port_we;
        ctl_we     = ctl_en && port_we;
        core_idx   = idx_q;
        dma_idx    = DMA_IDX_W'(idx_q);
        core_wdata = wr_word;
        dma_wdata  = wr_word;
        ctl_wdata  = wr_word;

        host_ready = (state_q == ST_DONE);
        host_rdata = rdata_q;

        rd_any = (core_en && !core_we) || (dma_en && !dma_we) || (ctl_en && !ctl_we);
        wr_any = core_we || dma_we || ctl_we;
    end

    assert_region_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({core_en, dma_en, ctl_en}));

    assert_single_read_R10: assert property (@(posedge clk) disable iff (rst)
        rd_any |=> !rd_any);

    assert_fetch_first_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_any && xfer_q.widen) |-> $past(rd_any));

    assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);

    assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (host_ready && $past(state_q == ST_IDLE)) |-> (host_rdata == 32'd0));

endmodule

// File: tb/tb_subword_adapter.sv
`timescale 1ns/1ps
module tb_subword_adapter;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_req;
    logic        host_we;
    logic [6:0]  host_addr;
    logic [1:0]  host_size;
    logic [31:0] host_wdata;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        core_en, core_we, dma_en, dma_we, ctl_en, ctl_we;
    logic [3:0]  core_idx;
    logic [2:0]  dma_idx;
    logic [31:0] core_wdata, dma_wdata, ctl_wdata;
    logic [31:0] core_rdata, dma_rdata, ctl_rdata;

    logic [31:0] core_m [16];
    logic [31:0] dma_m  [8];
    logic [31:0] ctl_m;
    int rd_cnt, wr_cnt;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    subword_adapter dut (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata),
        .core_en(core_en), .core_we(core_we), .core_idx(core_idx),
        .core_wdata(core_wdata), .core_rdata(core_rdata),
        .dma_en(dma_en), .dma_we(dma_we), .dma_idx(dma_idx),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .ctl_en(ctl_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata)
    );

    assign core_rdata = core_m[core_idx];
    assign dma_rdata  = dma_m[dma_idx];
    assign ctl_rdata  = ctl_m;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) core_m[i] <= {8'hC0, 8'(i), 8'h5A, 8'(i)};
            for (int i = 0; i < 8; i++)  dma_m[i]  <= {8'hD0, 8'(i), 8'hA5, 8'(i)};
            ctl_m  <= 32'h7070_A5C3;
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else begin
            if (core_en && core_we) core_m[core_idx] <= core_wdata;
            if (dma_en && dma_we)   dma_m[dma_idx]   <= dma_wdata;
            if (ctl_en && ctl_we)   ctl_m            <= ctl_wdata;
            if ((core_en && !core_we) || (dma_en && !dma_we) || (ctl_en && !ctl_we))
                rd_cnt <= rd_cnt + 1;
            if (core_we || dma_we || ctl_we)
                wr_cnt <= wr_cnt + 1;
        end
    end

    function automatic logic [31:0] exp_read(input logic [31:0] w, input int off, input int nbytes);
        logic [31:0] r = '0;
        for (int k = 0; k < nbytes; k++)
            if (off + k < 4) r[8*k +: 8] = w[8*(off+k) +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] cur, input logic [31:0] wd,
                                              input int off, input int nbytes);
        logic [31:0] r = cur;
        for (int k = 0; k < nbytes; k++)
            if (off + k < 4) r[8*(off+k) +: 8] = wd[8*k +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [6:0] a, input int nbytes, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc, output int nrd, output int nwr);
        int r0, w0;
        @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        host_req = 1'b1; host_we = we; host_addr = a;
        host_size = 2'(nbytes - 1); host_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!host_ready && cyc < 40);
        rd = host_rdata;
        host_req = 1'b0;
        nrd = rd_cnt - r0;
        nwr = wr_cnt - w0;
        if (!host_ready) check(1'b0, "handshake timeout", 32'(cyc), 32'd40);
    endtask

    task automatic test_reset;
        check(host_ready == 1'b0, "R1 ready", 32'(host_ready), 0);
        check(host_rdata == 32'd0, "R1 rdata", host_rdata, 0);
        check({core_en, dma_en, ctl_en} == 3'b000, "R1 enables", 32'({core_en, dma_en, ctl_en}), 0);
    endtask

    task automatic test_full_word;
        logic [31:0] rd; int c, nr, nw;
        access(1'b1, 7'h14, 4, 32'hCAFE_F00D, rd, c, nr, nw);
        check(core_m[5] == 32'hCAFE_F00D, "R6 R2 core[5] write", core_m[5], 32'hCAFE_F00D);
        check(c == 2, "R6 latency", 32'(c), 2);
        check(nr == 0 && nw == 1, "R6 strobes", 32'(nr * 16 + nw), 1);
        access(1'b0, 7'h14, 4, 0, rd, c, nr, nw);
        check(rd == 32'hCAFE_F00D, "R9 R2 full read", rd, 32'hCAFE_F00D);
        check(c == 2, "R9 latency", 32'(c), 2);
        check(nr == 1 && nw == 0, "R10 one read", 32'(nr * 16 + nw), 16);
        @(negedge clk);
        check(host_ready == 1'b0, "R11 single pulse", 32'(host_ready), 0);
    endtask

    task automatic test_narrow_writes;
        logic [31:0] rd, e; int c, nr, nw;
        e = exp_merge(core_m[5], 32'h0000_0077, 1, 1);
        access(1'b1, 7'h15, 1, 32'hFFFF_FF77, rd, c, nr, nw);
        check(core_m[5] == e, "R7 byte merge", core_m[5], e);
        check(c == 3, "R7 latency", 32'(c), 3);
        check(nr == 1 && nw == 1, "R10 R7 fetch+write", 32'(nr * 16 + nw), 17);
        e = exp_merge(dma_m[0], 32'h0000_BEEF, 2, 2);
        access(1'b1, 7'h42, 2, 32'h1234_BEEF, rd, c, nr, nw);
        check(dma_m[0] == e, "R3 R7 half merge dma[0]", dma_m[0], e);
        e = exp_merge(dma_m[2], 32'h4433_2211, 3, 4);
        access(1'b1, 7'h4B, 4, 32'h4433_2211, rd, c, nr, nw);
        check(dma_m[2] == e, "R8 lanes past bit 31 dropped", dma_m[2], e);
        e = exp_merge(core_m[9], 32'h00AB_CDEF, 2, 3);
        access(1'b1, 7'h26, 3, 32'h99AB_CDEF, rd, c, nr, nw);
        check(core_m[9] == e, "R8 three-byte at off2", core_m[9], e);
        e = exp_merge(core_m[15], 32'h0000_00E1, 3, 1);
        access(1'b1, 7'h3F, 1, 32'h0000_00E1, rd, c, nr, nw);
        check(core_m[15] == e, "R2 top core byte", core_m[15], e);
    endtask

    task automatic test_read_lanes;
        logic [31:0] rd, e, w; int c, nr, nw;
        w = 32'h8877_6655;
        access(1'b1, 7'h5C, 4, w, rd, c, nr, nw);
        for (int off = 0; off < 4; off++) begin
            for (int nb = 1; nb <= 4; nb++) begin
                e = exp_read(w, off, nb);
                access(1'b0, 7'(7'h5C + off), nb, 0, rd, c, nr, nw);
                check(rd == e, "R9 R3 lane extract dma[7]", rd, e);
                check(nr == 1, "R10 read count", 32'(nr), 1);
            end
        end
        e = exp_read(dma_m[0], 0, 1);
        access(1'b0, 7'h40, 1, 0, rd, c, nr, nw);
        check(rd == e, "R3 first dma byte", rd, e);
    endtask

    task automatic test_control;
        logic [31:0] rd, e; int c, nr, nw;
        e = exp_merge(ctl_m, 32'h0000_1E2D, 2, 2);
        access(1'b1, 7'h72, 2, 32'h0000_1E2D, rd, c, nr, nw);
        check(ctl_m == e, "R4 ctl half merge", ctl_m, e);
        access(1'b0, 7'h70, 4, 0, rd, c, nr, nw);
        check(rd == e, "R4 ctl full read", rd, e);
        access(1'b0, 7'h73, 1, 0, rd, c, nr, nw);
        check(rd == exp_read(e, 3, 1), "R4 ctl top byte", rd, exp_read(e, 3, 1));
    endtask

    task automatic test_unmapped;
        logic [31:0] rd, ctl0, dma7; int c, nr, nw;
        ctl0 = ctl_m; dma7 = dma_m[7];
        access(1'b0, 7'h60, 4, 0, rd, c, nr, nw);
        check(rd == 0 && c == 1 && nr == 0, "R5 read 0x60", rd, 0);
        access(1'b0, 7'h6D, 2, 0, rd, c, nr, nw);
        check(rd == 0 && nr == 0, "R5 read 0x6D", rd, 0);
        access(1'b0, 7'h7F, 1, 0, rd, c, nr, nw);
        check(rd == 0 && nr == 0, "R5 read 0x7F", rd, 0);
        access(1'b1, 7'h64, 4, 32'hDEAD_BEEF, rd, c, nr, nw);
        check(nr == 0 && nw == 0 && c == 1, "R5 write 0x64 quiet", 32'(nr * 16 + nw), 0);
        access(1'b1, 7'h74, 1, 32'h0000_00EE, rd, c, nr, nw);
        check(nr == 0 && nw == 0, "R5 write 0x74 quiet", 32'(nr * 16 + nw), 0);
        access(1'b0, 7'h70, 4, 0, rd, c, nr, nw);
        check(rd == ctl0, "R5 ctl unchanged", rd, ctl0);
        access(1'b0, 7'h5C, 4, 0, rd, c, nr, nw);
        check(rd == dma7, "R5 dma[7] unchanged", rd, dma7);
    endtask

    initial begin
        rst = 1'b1; host_req = 1'b0; host_we = 1'b0; host_addr = '0;
        host_size = '0; host_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset;
        rst = 1'b0;
        @(negedge clk);
        test_reset;
        test_full_word;
        test_narrow_writes;
        test_read_lanes;
        test_control;
        test_unmapped;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule